// File: doc/BRIEF.md
# Power-up reset and clock-start sequencer

This block walks a device out of reset through a chain of timed stages. A power-detect stage, a supply-good stage and a power-up timer come first. An oscillator-ready stage follows, and its length depends on the selected clock mode. After that the core is released and starts fetching at address zero. If the fail-safe clock monitor is configured, its enable comes on a further fixed number of cycles later. Every delay is a cycle count set by a parameter.

A cold reset is a power-on or brown-out event. It reloads the clock mode from the configuration input. A warm request, either a generic request or a software reset instruction, keeps the clock mode that is running. It also skips the supply stages. A sticky cause register records power-on, brown-out and software resets, and each bit is cleared by a write-one-to-clear strobe.

Top module: `pwrup_seq`

## Requirements
- R1: After a cold reset the stages run in a fixed order: power-detect, supply-good, power-up timer, oscillator-ready, run. A stage entered with its condition good lasts its limit plus one cycle: T_POR+1, T_BOR+1, T_PWRT+1, then the oscillator delay plus one.
- R2: `sys_rst` is high during the power-detect, supply-good and power-up timer stages. `osc_en` is always its complement, so the oscillator is enabled in the cycle after the power-up timer ends.
- R3: The oscillator delay comes from the clock mode code. Codes 0, 1 and 2 (fast RC and its divided forms) use T_OSCD. Code 3 (fast RC with PLL) uses T_OSCD+T_LOCK. Codes 4, 5 and 10 (crystal, high-speed crystal, secondary oscillator) use T_OSCD+1024. Codes 7 and 8 (crystal and high-speed crystal with PLL) use T_OSCD+1024+T_LOCK. Code 6 (external clock) uses 0. Code 9 (external clock with PLL) uses T_LOCK. Code 11 (low-power RC) uses T_OSCD_LP.
- R4: Codes 12 to 15 are treated as code 0, and `clk_mode` never reports a value above 11.
- R5: During cold stages `clk_mode` is loaded from `cfg_mode`. Outside them it holds its value, so a warm reset keeps the running mode.
- R6: `core_rst` falls when the oscillator-ready stage completes, and it is high whenever `sys_rst` is high.
- R7: With `fscm_cfg` high, `fscm_en` rises T_FSCM+1 cycles after `core_rst` falls. With `fscm_cfg` low it stays low.
- R8: If `por_ok` is low in any cycle, the next cycle is in the power-detect stage with its counter cleared. If `supply_good` is low while `por_ok` is high, the same happens with the supply-good stage (unless the block is already in the power-detect stage).
- R9: A warm request (`warm_req` or `sw_req`) works as follows. During the oscillator-ready stage it restarts that stage from zero. While the core runs it raises `core_rst` for one cycle and then releases it again, dropping `fscm_en`. During the three cold stages it is ignored.
- R10: `cause` bit 0 means power-on, bit 1 brown-out and bit 2 software reset; it resets to 3'b001. A bit is set by its event (bit 2 only for an `sw_req` outside the cold stages) and cleared by a one on the matching `cause_clr` bit, with set winning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| arst_n | input | 1 | Asynchronous reset, active low |
| por_ok | input | 1 | Power detected above threshold |
| supply_good | input | 1 | Supply above brown-out threshold |
| warm_req | input | 1 | Generic warm reset request |
| sw_req | input | 1 | Software reset instruction request |
| cfg_mode | input | 4 | Configured clock mode for cold reset |
| fscm_cfg | input | 1 | Fail-safe clock monitor configured |
| cause_clr | input | 3 | Write-one-to-clear strobe for `cause` |
| sys_rst | output | 1 | System reset, active high |
| osc_en | output | 1 | Oscillator enable |
| core_rst | output | 1 | Core held in reset, active high |
| fscm_en | output | 1 | Fail-safe clock monitor enable |
| clk_mode | output | 4 | Clock mode in use |
| cause | output | 3 | Sticky reset-cause flags |

## Verification
The hardest case to reach is a warm request that arrives while the oscillator-ready stage is already partway through. To get there, the stimulus first drops `por_ok` so that a short-delay mode is reloaded, then times a `warm_req` to land two cycles after `sys_rst` falls. The release must then slip by exactly the elapsed count. A `warm_req` sent during the power-up timer of the same sequence shows that it has no effect on when `sys_rst` falls. Each dip of the supply or power input is held for several cycles, so the bench also checks that counting starts from the last bad cycle.

// File: rtl/pwrup_pkg.sv
`timescale 1ns/1ps
package pwrup_pkg;

  typedef enum logic [2:0] {
    ST_POR  = 3'd0,
    ST_BOR  = 3'd1,
    ST_PWRT = 3'd2,
    ST_OSC  = 3'd3,
    ST_RUN  = 3'd4,
    ST_WARM = 3'd5,
    ST_MON  = 3'd6
  } stage_t;

  localparam logic [3:0] MD_FRC     = 4'd0;
  localparam logic [3:0] MD_FRCD16  = 4'd1;
  localparam logic [3:0] MD_FRCDN   = 4'd2;
  localparam logic [3:0] MD_FRCPLL  = 4'd3;
  localparam logic [3:0] MD_XT      = 4'd4;
  localparam logic [3:0] MD_HS      = 4'd5;
  localparam logic [3:0] MD_EC      = 4'd6;
  localparam logic [3:0] MD_XTPLL   = 4'd7;
  localparam logic [3:0] MD_HSPLL   = 4'd8;
  localparam logic [3:0] MD_ECPLL   = 4'd9;
  localparam logic [3:0] MD_SOSC    = 4'd10;
  localparam logic [3:0] MD_LPRC    = 4'd11;

  // Terms that make up the oscillator-ready wait
  typedef struct packed {
    logic fast;   // start-up delay of fast sources
    logic slow;   // start-up delay of the low-power RC
    logic ost;    // fixed start-up timer
    logic lock;   // PLL lock wait
  } osc_terms_t;

  function automatic logic [3:0] fold_mode(input logic [3:0] code);
    return (code > MD_LPRC) ? MD_FRC : code;
  endfunction

  function automatic osc_terms_t osc_terms(input logic [3:0] mode);
    osc_terms_t t;
    t = '0;
    case (mode)
      MD_FRCPLL:          begin t.fast = 1'b1; t.lock = 1'b1; end
      MD_XT, MD_HS,
      MD_SOSC:            begin t.fast = 1'b1; t.ost = 1'b1; end
      MD_XTPLL, MD_HSPLL: begin t.fast = 1'b1; t.ost = 1'b1; t.lock = 1'b1; end
      MD_EC:              t = '0;
      MD_ECPLL:           t.lock = 1'b1;
      MD_LPRC:            t.slow = 1'b1;
      default:            t.fast = 1'b1;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/seq_timer.sv
`timescale 1ns/1ps
module seq_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         done,
  output logic [W-1:0] cnt
);

  assign done = (cnt == limit);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (!done)  cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/osc_delay_calc.sv
`timescale 1ns/1ps
module osc_delay_calc
  import pwrup_pkg::*;
#(
  parameter int W          = 12,
  parameter int T_OSCD     = 6,
  parameter int T_OSCD_LP  = 30,
  parameter int OST_CYCLES = 1024,
  parameter int T_LOCK     = 50
) (
  input  logic [3:0]   mode,
  output logic [W-1:0] total
);

  osc_terms_t terms;

  assign terms = osc_terms(mode);

  assign total = (terms.fast ? W'(T_OSCD)     : '0)
               + (terms.slow ? W'(T_OSCD_LP)  : '0)
               + (terms.ost  ? W'(OST_CYCLES) : '0)
               + (terms.lock ? W'(T_LOCK)     : '0);

endmodule

// File: rtl/rst_cause_reg.sv
`timescale 1ns/1ps
module rst_cause_reg #(
  parameter int         N       = 3,
  parameter logic [N-1:0] RST_VAL = 3'b001
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flags
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)          flags[i] <= RST_VAL[i];
      else if (set_vec[i])  flags[i] <= 1'b1;
      else if (clr_vec[i])  flags[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/pwrup_seq.sv
`timescale 1ns/1ps
module pwrup_seq
  import pwrup_pkg::*;
#(
  parameter int T_POR      = 20,
  parameter int T_BOR      = 12,
  parameter int T_PWRT     = 40,
  parameter int T_OSCD     = 6,
  parameter int T_OSCD_LP  = 30,
  parameter int OST_CYCLES = 1024,
  parameter int T_LOCK     = 50,
  parameter int T_FSCM     = 16
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       por_ok,
  input  logic       supply_good,
  input  logic       warm_req,
  input  logic       sw_req,
  input  logic [3:0] cfg_mode,
  input  logic       fscm_cfg,
  input  logic [2:0] cause_clr,
  output logic       sys_rst,
  output logic       osc_en,
  output logic       core_rst,
  output logic       fscm_en,
  output logic [3:0] clk_mode,
  output logic [2:0] cause
);

  localparam int SPAN  = T_POR + T_BOR + T_PWRT + T_OSCD + T_OSCD_LP
                       + OST_CYCLES + T_LOCK + T_FSCM;
  localparam int CNT_W = $clog2(SPAN + 1);

  stage_t             stage, stage_nxt;
  logic               tmr_clr, tmr_done;
  logic [CNT_W-1:0]   tmr_cnt, tmr_lim, osc_lim;
  logic [3:0]         mode_q;
  logic               warm_any, cold_stage;

  // named events for the checker
  logic               lim_breach;
  logic               evt_release;
  logic [2:0]         cause_set;

  assign warm_any   = warm_req | sw_req;
  assign cold_stage = (stage == ST_POR) || (stage == ST_BOR) || (stage == ST_PWRT);

  osc_delay_calc #(
    .W(CNT_W), .T_OSCD(T_OSCD), .T_OSCD_LP(T_OSCD_LP),
    .OST_CYCLES(OST_CYCLES), .T_LOCK(T_LOCK)
  ) u_osc_calc (
    .mode  (mode_q),
    .total (osc_lim)
  );

  always_comb begin
    case (stage)
      ST_POR:  tmr_lim = CNT_W'(T_POR);
      ST_BOR:  tmr_lim = CNT_W'(T_BOR);
      ST_PWRT: tmr_lim = CNT_W'(T_PWRT);
      ST_OSC:  tmr_lim = osc_lim;
      ST_RUN:  tmr_lim = CNT_W'(T_FSCM);
      default: tmr_lim = '0;
    endcase
  end

  seq_timer #(.W(CNT_W)) u_timer (
    .clk    (clk),
    .arst_n (arst_n),
    .clr    (tmr_clr),
    .limit  (tmr_lim),
    .done   (tmr_done),
    .cnt    (tmr_cnt)
  );

  assign lim_breach = (tmr_cnt > tmr_lim);

  always_comb begin
    stage_nxt = stage;
    tmr_clr   = 1'b0;
    if (!por_ok) begin
      stage_nxt = ST_POR;
      tmr_clr   = 1'b1;
    end else if (!supply_good && stage != ST_POR) begin
      stage_nxt = ST_BOR;
      tmr_clr   = 1'b1;
    end else begin
      case (stage)
        ST_POR:  if (tmr_done) begin stage_nxt = ST_BOR;  tmr_clr = 1'b1; end
        ST_BOR:  if (tmr_done) begin stage_nxt = ST_PWRT; tmr_clr = 1'b1; end
        ST_PWRT: if (tmr_done) begin stage_nxt = ST_OSC;  tmr_clr = 1'b1; end
        ST_OSC: begin
          if (warm_any)      tmr_clr = 1'b1;
          else if (tmr_done) begin stage_nxt = ST_RUN; tmr_clr = 1'b1; end
        end
        ST_RUN: begin
          if (warm_any) begin
            stage_nxt = ST_WARM; tmr_clr = 1'b1;
          end else if (tmr_done && fscm_cfg) begin
            stage_nxt = ST_MON;  tmr_clr = 1'b1;
          end
        end
        ST_MON:  if (warm_any) begin stage_nxt = ST_WARM; tmr_clr = 1'b1; end
        ST_WARM: begin stage_nxt = ST_RUN; tmr_clr = 1'b1; end
        default: begin stage_nxt = ST_POR; tmr_clr = 1'b1; end
      endcase
    end
  end

  assign evt_release = (stage == ST_OSC) && (stage_nxt == ST_RUN);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage <= ST_POR;
    else         stage <= stage_nxt;
  end

  // clock mode: reloaded only while a cold sequence is running
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)         mode_q <= MD_FRC;
    else if (cold_stage) mode_q <= fold_mode(cfg_mode);
  end

  assign cause_set = { sw_req & ~cold_stage & por_ok & supply_good,
                       por_ok & ~supply_good,
                       ~por_ok };

  rst_cause_reg #(.N(3), .RST_VAL(3'b001)) u_cause (
    .clk     (clk),
    .arst_n  (arst_n),
    .set_vec (cause_set),
    .clr_vec (cause_clr),
    .flags   (cause)
  );

  assign sys_rst  = cold_stage;
  assign osc_en   = ~cold_stage;
  assign core_rst = ~((stage == ST_RUN) || (stage == ST_MON));
  assign fscm_en  = (stage == ST_MON);
  assign clk_mode = mode_q;

endmodule

// File: rtl/pwrup_seq_chk.sv
`timescale 1ns/1ps
module pwrup_seq_chk
  import pwrup_pkg::*;
(
  input logic       clk,
  input logic       arst_n,
  input logic       por_ok,
  input logic       sw_req,
  input logic       sys_rst,
  input logic       core_rst,
  input logic       fscm_en,
  input logic [3:0] clk_mode,
  input logic [2:0] cause,
  input stage_t     stage,
  input logic       lim_breach,
  input logic       evt_release
);

  assert_por_restart_R8: assert property (@(posedge clk) disable iff (!arst_n)
    !por_ok |=> (stage == ST_POR) && sys_rst);

  assert_order_R1: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(sys_rst) |-> ($past(stage) == ST_PWRT));

  assert_timer_bound_R1: assert property (@(posedge clk) disable iff (!arst_n)
    !lim_breach);

  assert_core_gate_R6: assert property (@(posedge clk) disable iff (!arst_n)
    sys_rst |-> core_rst);

  assert_release_R6: assert property (@(posedge clk) disable iff (!arst_n)
    evt_release |=> !core_rst);

  assert_fscm_after_core_R7: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(fscm_en) |-> $past(!core_rst));

  assert_mode_hold_R5: assert property (@(posedge clk) disable iff (!arst_n)
    !sys_rst |=> $stable(clk_mode));

  assert_code_range_R4: assert property (@(posedge clk) disable iff (!arst_n)
    clk_mode <= 4'd11);

  assert_sw_flag_R10: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(cause[2]) |-> $past(sw_req));

endmodule

bind pwrup_seq pwrup_seq_chk u_chk (
  .clk         (clk),
  .arst_n      (arst_n),
  .por_ok      (por_ok),
  .sw_req      (sw_req),
  .sys_rst     (sys_rst),
  .core_rst    (core_rst),
  .fscm_en     (fscm_en),
  .clk_mode    (clk_mode),
  .cause       (cause),
  .stage       (stage),
  .lim_breach  (lim_breach),
  .evt_release (evt_release)
);

// File: tb/test_pwrup_seq.sv
`timescale 1ns/1ps
module test_pwrup_seq;

  localparam int P_POR = 20, P_BOR = 12, P_PWRT = 40, P_OSCD = 6;
  localparam int P_OSCD_LP = 30, P_OST = 1024, P_LOCK = 50, P_FSCM = 16;

  localparam int K_SYS_FALL = 0, K_SYS_RISE = 1, K_CORE_FALL = 2;
  localparam int K_CORE_RISE = 3, K_FSCM_RISE = 4, K_FSCM_FALL = 5;

  logic       clk = 1'b0;
  logic       arst_n = 1'b0;
  logic       por_ok = 1'b1, supply_good = 1'b1;
  logic       warm_req = 1'b0, sw_req = 1'b0;
  logic [3:0] cfg_mode = 4'd4;
  logic       fscm_cfg = 1'b1;
  logic [2:0] cause_clr = 3'b000;
  logic       sys_rst, osc_en, core_rst, fscm_en;
  logic [3:0] clk_mode;
  logic [2:0] cause;

  int cyc = 0;
  int n_chk = 0, n_bad = 0;
  int q_kind[$];
  int q_cyc[$];
  string q_tag[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwrup_seq #(
    .T_POR(P_POR), .T_BOR(P_BOR), .T_PWRT(P_PWRT), .T_OSCD(P_OSCD),
    .T_OSCD_LP(P_OSCD_LP), .OST_CYCLES(P_OST), .T_LOCK(P_LOCK), .T_FSCM(P_FSCM)
  ) i_pwrup_seq (
    .clk(clk), .arst_n(arst_n), .por_ok(por_ok), .supply_good(supply_good),
    .warm_req(warm_req), .sw_req(sw_req), .cfg_mode(cfg_mode),
    .fscm_cfg(fscm_cfg), .cause_clr(cause_clr), .sys_rst(sys_rst),
    .osc_en(osc_en), .core_rst(core_rst), .fscm_en(fscm_en),
    .clk_mode(clk_mode), .cause(cause)
  );

  // expected oscillator wait, built from which terms a mode carries
  function automatic int osc_wait(int code);
    int c, base;
    bit xtal, pll;
    c    = (code > 11) ? 0 : code;
    xtal = (c == 4) || (c == 5) || (c == 7) || (c == 8) || (c == 10);
    pll  = (c == 3) || (c == 7) || (c == 8) || (c == 9);
    if (c == 11)                base = P_OSCD_LP;
    else if (c == 6 || c == 9)  base = 0;
    else                        base = P_OSCD;
    return base + (xtal ? P_OST : 0) + (pll ? P_LOCK : 0);
  endfunction

  task automatic expect_evt(int kind, int at, string tag);
    q_kind.push_back(kind);
    q_cyc.push_back(at);
    q_tag.push_back(tag);
  endtask

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic take(int kind);
    int ek, ec;
    string et;
    n_chk++;
    if (q_kind.size() == 0) begin
      n_bad++;
      $display("FAIL R1 unexpected event: actual %0d at cycle %0d expected none", kind, cyc);
    end else begin
      ek = q_kind.pop_front();
      ec = q_cyc.pop_front();
      et = q_tag.pop_front();
      if (ek != kind || ec != cyc) begin
        n_bad++;
        $display("FAIL %s: actual event %0d at cycle %0d expected event %0d at cycle %0d",
                 et, kind, cyc, ek, ec);
      end
    end
    if (kind == K_SYS_FALL || kind == K_SYS_RISE)
      check("R2 osc_en complement", int'(osc_en), int'(!sys_rst));
  endtask

  // monitor: stamps output edges and compares against the scoreboard
  bit   mon_on = 1'b0;
  logic p_sys = 1'b1, p_core = 1'b1, p_fs = 1'b0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (sys_rst && !p_sys)   take(K_SYS_RISE);
      if (!sys_rst && p_sys)   take(K_SYS_FALL);
      if (core_rst && !p_core) take(K_CORE_RISE);
      if (!core_rst && p_core) take(K_CORE_FALL);
      if (fscm_en && !p_fs)    take(K_FSCM_RISE);
      if (!fscm_en && p_fs)    take(K_FSCM_FALL);
    end
    p_sys  = sys_rst;
    p_core = core_rst;
    p_fs   = fscm_en;
  end

  task automatic to_cyc(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic clear_cause(logic [2:0] m);
    @(negedge clk); cause_clr = m;
    @(negedge clk); cause_clr = 3'b000;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int k, e, s, r;
    repeat (3) @(negedge clk);
    // reset state
    check("R2 sys_rst in reset", int'(sys_rst), 1);
    check("R2 osc_en in reset", int'(osc_en), 0);
    check("R6 core_rst in reset", int'(core_rst), 1);
    check("R7 fscm_en in reset", int'(fscm_en), 0);
    check("R10 cause reset value", int'(cause), 1);

    // A: power-up with crystal mode, monitor configured
    @(negedge clk); e = cyc; arst_n = 1'b1; mon_on = 1'b1;
    s = e + P_POR + P_BOR + P_PWRT + 3;
    r = s + osc_wait(4) + 1;
    expect_evt(K_SYS_FALL, s, "R1 cold order");
    expect_evt(K_CORE_FALL, r, "R3 crystal wait");
    expect_evt(K_FSCM_RISE, r + P_FSCM + 1, "R7 monitor delay");
    to_cyc(r + P_FSCM + 4);
    check("R5 cold load mode 4", int'(clk_mode), 4);
    check("R10 power-on flag", int'(cause), 1);
    clear_cause(3'b001);
    check("R10 w1c clear", int'(cause), 0);

    // B: software reset while monitoring; mode must not follow cfg
    cfg_mode = 4'd6;
    @(negedge clk); k = cyc; sw_req = 1'b1;
    expect_evt(K_CORE_RISE, k + 1, "R9 warm core pulse");
    expect_evt(K_FSCM_FALL, k + 1, "R9 warm drops monitor");
    expect_evt(K_CORE_FALL, k + 2, "R9 warm release");
    expect_evt(K_FSCM_RISE, k + 2 + P_FSCM + 1, "R7 monitor after warm");
    @(negedge clk); sw_req = 1'b0;
    to_cyc(k + P_FSCM + 8);
    check("R5 warm keeps mode", int'(clk_mode), 4);
    check("R10 software flag", int'(cause), 4);
    clear_cause(3'b100);

    // C: brown-out for five cycles, external clock reloaded
    @(negedge clk); k = cyc; supply_good = 1'b0;
    expect_evt(K_SYS_RISE, k + 1, "R8 brown-out restart");
    expect_evt(K_CORE_RISE, k + 1, "R8 brown-out core");
    expect_evt(K_FSCM_FALL, k + 1, "R8 brown-out monitor");
    repeat (5) @(negedge clk);
    supply_good = 1'b1; e = cyc;
    s = e + P_BOR + P_PWRT + 2;
    r = s + osc_wait(6) + 1;
    expect_evt(K_SYS_FALL, s, "R1 supply stage length");
    expect_evt(K_CORE_FALL, r, "R3 external clock no wait");
    expect_evt(K_FSCM_RISE, r + P_FSCM + 1, "R7 monitor after brown-out");
    to_cyc(r + P_FSCM + 4);
    check("R5 cold load mode 6", int'(clk_mode), 6);
    check("R8 brown-out flag", int'(cause), 2);
    clear_cause(3'b010);

    // D: power dip, unused code, warm in timer stage and in oscillator stage
    fscm_cfg = 1'b0; cfg_mode = 4'd13;
    @(negedge clk); k = cyc; por_ok = 1'b0;
    expect_evt(K_SYS_RISE, k + 1, "R8 power dip");
    expect_evt(K_CORE_RISE, k + 1, "R8 power dip core");
    expect_evt(K_FSCM_FALL, k + 1, "R8 power dip monitor");
    repeat (3) @(negedge clk);
    por_ok = 1'b1; e = cyc;
    s = e + P_POR + P_BOR + P_PWRT + 3;
    expect_evt(K_SYS_FALL, s, "R9 warm ignored in timer stage");
    expect_evt(K_CORE_FALL, s + 10, "R9 warm restarts oscillator stage");
    to_cyc(e + P_POR + P_BOR + 5);
    warm_req = 1'b1;
    @(negedge clk); warm_req = 1'b0;
    to_cyc(s + 2);
    warm_req = 1'b1;
    @(negedge clk); warm_req = 1'b0;
    to_cyc(s + 40);
    check("R4 unused code folds to 0", int'(clk_mode), 0);
    check("R8 power-on flag only", int'(cause), 1);
    check("R7 monitor off when not configured", int'(fscm_en), 0);
    clear_cause(3'b001);

    // E: single-cycle power dip, external clock with PLL
    cfg_mode = 4'd9;
    @(negedge clk); k = cyc; por_ok = 1'b0;
    expect_evt(K_SYS_RISE, k + 1, "R8 one-cycle dip");
    expect_evt(K_CORE_RISE, k + 1, "R8 one-cycle dip core");
    @(negedge clk); por_ok = 1'b1; e = cyc;
    s = e + P_POR + P_BOR + P_PWRT + 3;
    expect_evt(K_SYS_FALL, s, "R1 power stage length");
    expect_evt(K_CORE_FALL, s + osc_wait(9) + 1, "R3 PLL lock only");
    to_cyc(s + osc_wait(9) + 5);
    check("R3 mode 9 loaded", int'(clk_mode), 9);

    // F: brown-out, low-power RC
    cfg_mode = 4'd11;
    @(negedge clk); k = cyc; supply_good = 1'b0;
    expect_evt(K_SYS_RISE, k + 1, "R8 brown-out again");
    expect_evt(K_CORE_RISE, k + 1, "R8 brown-out again core");
    repeat (2) @(negedge clk);
    supply_good = 1'b1; e = cyc;
    s = e + P_BOR + P_PWRT + 2;
    expect_evt(K_SYS_FALL, s, "R2 oscillator enabled after timer");
    expect_evt(K_CORE_FALL, s + osc_wait(11) + 1, "R3 low-power RC wait");
    to_cyc(s + osc_wait(11) + 5);
    check("R3 mode 11 loaded", int'(clk_mode), 11);
    check("R10 brown-out and power-on kept", int'(cause), 3);

    to_cyc(cyc + 5);
    check("R1 all expected events seen", q_kind.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule